// File: doc/BRIEF.md
# GPIO Bank Controller with Edge Interrupts

This block manages a bank of general-purpose I/O channels. Each channel has one 8-bit control byte that picks the output driver style (open-drain or push-pull), the direction, the level to drive, the interrupt edge mode and an input debounce time. Each channel drives an output-enable and an output-value line for its pad. Pin inputs pass through a two-flop synchronizer and an optional debouncer before software reads them back or the edge detector sees them.

A shared flag register holds one interrupt flag per channel. Reading it clears the flags it returns. The block raises one summary request line whenever any flag is set, which a first-level interrupt controller consumes. Software reaches the block over a simple register bus: writes take effect at the clock edge, and read data is registered, so it is valid one cycle after the read strobe.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every control byte reads 0x02 with bit 2 showing the pin level. This means input mode, interrupts masked and no debounce. The flag register reads 0x00, and `pad_oe`, `pad_out` and `irq` are low.
- R2: When control bit 1 (direction) is 1, the channel is an input. `pad_oe` goes low on the next clock whatever bits 0 and 3 hold.
- R3: Bit 1 = 0 and bit 0 = 0 select open-drain output. If bit 3 is 1, `pad_oe` is low (high-impedance). If bit 3 is 0, `pad_oe` is high and `pad_out` is low. Pads update one clock after the control byte changes.
- R4: Bit 1 = 0 and bit 0 = 1 select push-pull output. `pad_oe` is high and `pad_out` equals bit 3, one clock after the control byte changes.
- R5: Bit 3 can be written while the channel is an input and reads back as written. The stored level appears on the pad only once bit 1 returns to 0.
- R6: A read of control address n (0 to NCH-1) returns the stored byte, except that bit 2 shows the channel's debounced input level. Writes to bit 2 are ignored.
- R7: Bits 7:6 select debounce. 00 passes the synchronized level three clocks after the pin changes. 01, 10 and 11 accept a new level only after it has held for 10, 20 or 30 `ms_tick` pulses. A return to the old level restarts the count.
- R8: Bits 5:4 select edge detection on the debounced level, in input mode only. 00 never sets a flag, 01 flags falling edges, 10 flags rising edges and 11 flags both.
- R9: Address NCH is the read-only flag register, with bit n belonging to channel n. Writes to it have no effect. Other unused addresses read 0. `irq` is high exactly when any flag is set.
- R10: A read of the flag register clears the flags it returned. An edge that lands in the same cycle as that read stays set and is returned by the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond, used as the debounce time base |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address: channels 0..NCH-1, then the flag register at NCH |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after `bus_rd` |
| pin_in | input | NCH | Raw pad input levels |
| pad_oe | output | NCH | Pad output enable, one bit per channel |
| pad_out | output | NCH | Pad output value, one bit per channel |
| irq | output | 1 | Summary interrupt request |

## Verification
The collision that matters is an edge event and a clear-on-read of the flag register landing in the same cycle. The bench provokes it by changing a pin exactly three clocks before the read strobe is sampled. Counting the synchronizer, the debouncer and the edge register, that puts the new edge on the clearing edge. A behavioural model updated every clock judges the outcome. It expects the read to return the old flags, the new flag to survive, and the following read to return and clear it. Debounce restarts and all pad combinations are compared against the same model on every cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef struct packed {
    logic [1:0] deb_sel;    // [7:6] debounce length selector
    logic [1:0] edge_mode;  // [5:4] bit5 rising, bit4 falling
    logic       dout;       // [3]   desired output level
    logic       lvl_ro;     // [2]   readback slot, not stored as state
    logic       dir_in;     // [1]   1 = input
    logic       push_pull;  // [0]   1 = push-pull, 0 = open-drain
  } gpio_ctrl_t;

  localparam logic [7:0] CTRL_RST = 8'h02;
endpackage

// File: rtl/gpio_sync_deb.sv
module gpio_sync_deb #(
  parameter int STEP = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ms_tick,
  input  logic       pin_raw,
  input  logic [1:0] deb_sel,
  output logic       level
);
  localparam int CW = $clog2(3 * STEP + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;
  logic [CW-1:0] target;

  assign target = CW'(STEP) * CW'(deb_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      level <= 1'b0;
      cnt   <= '0;
    end else begin
      s1 <= pin_raw;
      s2 <= s1;
      if (deb_sel == 2'b00) begin
        level <= s2;
        cnt   <= '0;
      end else if (s2 == level) begin
        cnt <= '0;
      end else if (ms_tick) begin
        if (cnt + CW'(1) >= target) begin
          level <= s2;
          cnt   <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/gpio_chan.sv
module gpio_chan
  import gpio_pkg::*;
#(
  parameter int STEP = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ms_tick,
  input  logic       pin_raw,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_q,
  output logic       level,
  output logic       pad_oe,
  output logic       pad_out,
  output logic       edge_hit
);
  gpio_ctrl_t cfg;
  logic       level_prev;

  always_ff @(posedge clk) begin
    if (rst) cfg <= gpio_ctrl_t'(CTRL_RST);
    else if (cfg_we) cfg <= gpio_ctrl_t'(cfg_wdata);
  end

  assign cfg_q = cfg;

  gpio_sync_deb #(.STEP(STEP)) u_deb (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .pin_raw(pin_raw),
    .deb_sel(cfg.deb_sel), .level(level)
  );

  // previous level follows every cycle, so a mode change never sees a stale value
  always_ff @(posedge clk) begin
    if (rst) level_prev <= 1'b0;
    else     level_prev <= level;
  end

  assign edge_hit = cfg.dir_in &&
                    ((cfg.edge_mode[1] && level && !level_prev) ||
                     (cfg.edge_mode[0] && !level && level_prev));

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe  <= 1'b0;
      pad_out <= 1'b0;
    end else begin
      pad_oe  <= !cfg.dir_in && (cfg.push_pull || !cfg.dout);
      pad_out <= !cfg.dir_in && cfg.push_pull && cfg.dout;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NCH    = 4,
  parameter int STEP   = 10,
  parameter int ADDR_W = $clog2(NCH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ms_tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [NCH-1:0]    pin_in,
  output logic [NCH-1:0]    pad_oe,
  output logic [NCH-1:0]    pad_out,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(NCH);

  logic [NCH*8-1:0] ctrl_all;
  logic [NCH*8-1:0] ctrl_rd;
  logic [NCH-1:0]   lvl;
  logic [NCH-1:0]   hit;
  logic [NCH-1:0]   flags_q, flags_d, flag_clr;
  logic [7:0]       flag_byte;
  logic [7:0]       rd_val;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [7:0] cq;
    gpio_chan #(.STEP(STEP)) u_ch (
      .clk(clk), .rst(rst), .ms_tick(ms_tick), .pin_raw(pin_in[g]),
      .cfg_we(bus_wr && bus_addr == ADDR_W'(g)), .cfg_wdata(bus_wdata),
      .cfg_q(cq), .level(lvl[g]), .pad_oe(pad_oe[g]), .pad_out(pad_out[g]),
      .edge_hit(hit[g])
    );
    assign ctrl_all[g*8 +: 8] = cq;
    assign ctrl_rd[g*8 +: 8]  = {cq[7:3], lvl[g], cq[1:0]};
  end

  assign flag_clr = (bus_rd && bus_addr == FLAG_ADDR) ? flags_q : '0;
  assign flags_d  = (flags_q & ~flag_clr) | hit;

  always_comb begin
    flag_byte = '0;
    flag_byte[NCH-1:0] = flags_q;
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NCH; i++)
      if (bus_addr == ADDR_W'(i)) rd_val = ctrl_rd[i*8 +: 8];
    if (bus_addr == FLAG_ADDR) rd_val = flag_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q   <= '0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      flags_q <= flags_d;
      irq     <= |flags_d;
      if (bus_rd) bus_rdata <= rd_val;
    end
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NCH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [NCH-1:0]   pad_oe,
  input logic [NCH-1:0]   pad_out,
  input logic             irq,
  input logic [NCH*8-1:0] ctrl_all,
  input logic [NCH-1:0]   flags
);
  for (genvar g = 0; g < NCH; g++) begin : g_a
    AST_INPUT_RELEASES_PAD: assert property (@(posedge clk) disable iff (rst)
      ctrl_all[g*8+1] |=> !pad_oe[g]); // R2
    AST_OPEN_DRAIN_HIGHZ: assert property (@(posedge clk) disable iff (rst)
      (!ctrl_all[g*8+1] && !ctrl_all[g*8] && ctrl_all[g*8+3]) |=> !pad_oe[g]); // R3
    AST_OPEN_DRAIN_LOW: assert property (@(posedge clk) disable iff (rst)
      (!ctrl_all[g*8+1] && !ctrl_all[g*8] && !ctrl_all[g*8+3]) |=> (pad_oe[g] && !pad_out[g])); // R3
    AST_PUSH_PULL_DRIVES: assert property (@(posedge clk) disable iff (rst)
      (!ctrl_all[g*8+1] && ctrl_all[g*8]) |=> (pad_oe[g] && pad_out[g] == $past(ctrl_all[g*8+3]))); // R4
    AST_MASKED_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
      (ctrl_all[g*8+5 -: 2] == 2'b00 && !flags[g]) |=> !flags[g]); // R8
  end

  AST_IRQ_SUMMARY: assert property (@(posedge clk) disable iff (rst)
    irq == (|flags)); // R9
endmodule

bind gpio_bank gpio_bank_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq),
  .ctrl_all(ctrl_all), .flags(flags_q)
);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 4;
  localparam int STEP = 10;
  localparam int AW   = $clog2(NCH + 1);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           ms_tick = 1'b0;
  logic           bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic [7:0]     bus_wdata = '0;
  logic [7:0]     bus_rdata;
  logic [NCH-1:0] pin_in = '0;
  logic [NCH-1:0] pad_oe, pad_out;
  logic           irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  gpio_bank #(.NCH(NCH), .STEP(STEP)) u_dut (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [7:0]     m_ctrl [NCH];
  int             m_cnt  [NCH];
  logic [NCH-1:0] m_s1, m_s2, m_deb, m_prev, m_flag, m_oe, m_out;
  logic           m_irq;
  logic [7:0]     m_rdata;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin m_ctrl[i] = 8'h02; m_cnt[i] = 0; end
      m_s1 = '0; m_s2 = '0; m_deb = '0; m_prev = '0; m_flag = '0;
      m_oe = '0; m_out = '0; m_irq = 0; m_rdata = '0;
    end else begin
      logic [NCH-1:0] nflag, ndeb;
      logic [7:0]     rv;
      rv = 8'h00;
      if (bus_rd) begin
        if (int'(bus_addr) < NCH)
          rv = {m_ctrl[bus_addr][7:3], m_deb[bus_addr], m_ctrl[bus_addr][1:0]};
        else if (int'(bus_addr) == NCH) rv = 8'(m_flag);
        m_rdata = rv;
      end
      nflag = m_flag;
      if (bus_rd && int'(bus_addr) == NCH) nflag = '0;
      ndeb = m_deb;
      for (int i = 0; i < NCH; i++) begin
        logic [7:0] c;
        int tgt;
        c = m_ctrl[i];
        if (c[1] && ((c[5] && m_deb[i] && !m_prev[i]) || (c[4] && !m_deb[i] && m_prev[i])))
          nflag[i] = 1'b1;
        m_oe[i]  = !c[1] && (c[0] || !c[3]);
        m_out[i] = !c[1] && c[0] && c[3];
        tgt = STEP * int'(c[7:6]);
        if (tgt == 0) begin ndeb[i] = m_s2[i]; m_cnt[i] = 0; end
        else if (m_s2[i] == m_deb[i]) m_cnt[i] = 0;
        else if (ms_tick) begin
          if (m_cnt[i] + 1 >= tgt) begin ndeb[i] = m_s2[i]; m_cnt[i] = 0; end
          else m_cnt[i] = m_cnt[i] + 1;
        end
      end
      if (bus_wr && int'(bus_addr) < NCH) m_ctrl[bus_addr] = bus_wdata;
      m_prev = m_deb;
      m_deb  = ndeb;
      m_s2   = m_s1;
      m_s1   = pin_in;
      m_flag = nflag;
      m_irq  = |nflag;
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(32'(pad_oe),  32'(m_oe),  "R2/R3/R4 pad_oe vs model");
      check(32'(pad_out), 32'(m_out), "R3/R4/R5 pad_out vs model");
      check(32'(irq),     32'(m_irq), "R9 irq vs model");
      check(32'(bus_rdata), 32'(m_rdata), "R6/R10 rdata vs model");
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      ms_tick = ~ms_tick;
    end
  end

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [7:0] exp, input string tag);
    @(negedge clk); bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk); bus_rd = 1'b0;
    check(32'(bus_rdata), 32'(exp), tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setpin(input int ch, input logic v);
    @(negedge clk); pin_in[ch] = v;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    done = 1;
    summary();
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    check(32'(pad_oe), 0, "R1 pad_oe after reset");
    check(32'(irq), 0, "R1 irq after reset");
    for (int i = 0; i < NCH; i++) rd(i, 8'h02, "R1 control reset value");
    rd(NCH, 8'h00, "R1 flag register reset");

    // R4 push-pull on channel 0
    wr(0, 8'h01); idle(1);
    check(32'(pad_oe[0]), 1, "R4 push-pull enabled");
    check(32'(pad_out[0]), 0, "R4 push-pull low");
    wr(0, 8'h09); idle(1);
    check(32'(pad_out[0]), 1, "R4 push-pull high");

    // R3 open-drain on channel 1
    wr(1, 8'h00); idle(1);
    check(32'(pad_oe[1]), 1, "R3 open-drain drives low");
    check(32'(pad_out[1]), 0, "R3 open-drain low value");
    wr(1, 8'h08); idle(1);
    check(32'(pad_oe[1]), 0, "R3 open-drain released");

    // R2 / R5 input mode holds output level
    wr(2, 8'h0B); idle(1);
    check(32'(pad_oe[2]), 0, "R2 input ignores drive bits");
    rd(2, 8'h0B, "R5 dout readable in input mode");
    wr(2, 8'h09); idle(1);
    check(32'(pad_oe[2]), 1, "R5 stored level applied");
    check(32'(pad_out[2]), 1, "R5 stored level high");

    // R6 readback of pin level, bit 2 not writable
    wr(2, 8'h06); setpin(2, 1'b1); idle(4);
    rd(2, 8'h06, "R6 readback high level");
    setpin(2, 1'b0); idle(4);
    rd(2, 8'h02, "R6 bit2 write ignored");

    // R8 edge modes on channel 3
    wr(3, 8'h22); setpin(3, 1'b1); idle(6);
    check(32'(irq), 1, "R9 irq on rising flag");
    rd(NCH, 8'h08, "R8 rising edge flag");
    rd(NCH, 8'h00, "R10 flag cleared by read");
    setpin(3, 1'b0); idle(6);
    rd(NCH, 8'h00, "R8 rising mode ignores fall");
    wr(3, 8'h12); setpin(3, 1'b1); idle(6);
    rd(NCH, 8'h00, "R8 falling mode ignores rise");
    setpin(3, 1'b0); idle(6);
    rd(NCH, 8'h08, "R8 falling edge flag");
    wr(3, 8'h32); setpin(3, 1'b1); idle(6);
    rd(NCH, 8'h08, "R8 both mode rise");
    setpin(3, 1'b0); idle(6);
    rd(NCH, 8'h08, "R8 both mode fall");
    wr(3, 8'h02); setpin(3, 1'b1); idle(6);
    rd(NCH, 8'h00, "R8 masked no flag");
    setpin(3, 1'b0); idle(6);

    // R10 edge landing on the clearing read
    wr(3, 8'h22); idle(2);
    setpin(3, 1'b1); idle(2);
    rd(NCH, 8'h00, "R10 read same cycle as edge");
    rd(NCH, 8'h08, "R10 edge survived clear");
    rd(NCH, 8'h00, "R10 cleared afterwards");
    wr(3, 8'h02); setpin(3, 1'b0); idle(6);

    // R9 flag register is read-only, spare address reads zero
    wr(NCH, 8'hFF); idle(1);
    rd(NCH, 8'h00, "R9 flag write ignored");
    check(32'(irq), 0, "R9 irq low with no flags");
    if (NCH + 1 < (1 << AW)) rd(NCH + 1, 8'h00, "R9 unused address");

    // R7 debounce 10 ticks (tick every 2 clocks)
    wr(3, 8'h62); idle(2);
    setpin(3, 1'b1); idle(8); setpin(3, 1'b0); idle(40);
    rd(3, 8'h62, "R7 short pulse rejected");
    rd(NCH, 8'h00, "R7 no flag from short pulse");
    setpin(3, 1'b1); idle(10);
    rd(3, 8'h62, "R7 not accepted early");
    idle(40);
    rd(3, 8'h66, "R7 accepted after 10 ticks");
    rd(NCH, 8'h08, "R7 debounced edge flagged");
    // 30 ticks, with a restart midway
    wr(3, 8'hE2);
    setpin(3, 1'b0); idle(40);
    setpin(3, 1'b1); idle(2);
    setpin(3, 1'b0); idle(40);
    rd(3, 8'hE6, "R7 restart keeps old level");
    idle(40);
    rd(3, 8'hE2, "R7 accepted after 30 ticks");
    // 20 ticks
    wr(3, 8'hA2); setpin(3, 1'b1); idle(30);
    rd(3, 8'hA2, "R7 20-tick not yet");
    idle(20);
    rd(3, 8'hA6, "R7 20-tick accepted");

    idle(4);
    done = 1;
    summary();
    $finish;
  end
endmodule